// File: doc/BRIEF.md
# Remappable Pin Crossbar

This block sits between a bank of digital peripherals and a set of device pins whose function software can choose. Each peripheral input owns a selection field that names the pin feeding it. Each pin owns a selection field that names the peripheral output driving it. The inputs are therefore steered per peripheral, and the outputs per pin. A small synchronous register port loads and reads back these fields. Every configuration register packs two selection fields.

For each pin, the output path is resolved with a fixed order of precedence. A dedicated function on the pin wins first. A remapped peripheral output comes next. Plain port data and port direction come last. A pin that is flagged analog hides its level from every remapped input that selects it. One control bit sends the serial clock output to its own fixed pad instead of through the pin table. While that bit is set, any table entry that names the clock is blanked.

The routing logic is combinational from pins, peripheral outputs and stored configuration to the pad and peripheral-input outputs. Only the configuration registers are clocked.

Top module: `pin_xbar`

## Requirements
- R1: Configuration register layout:
  - Registers 0 to 2 hold the peripheral input fields, two per register. The lower-numbered input sits in bits [5:0] and the higher one in bits [13:8].
  - Registers 3 to 6 hold the pin fields in the same way. Register 3 covers pins 0 and 1, and register 6 covers pins 6 and 7.
  - Register 7 bit 0 is the alternate clock enable.
  - A write with `cfg_we` high takes effect at that rising edge. `cfg_rdata` returns the stored fields combinationally, with all other bits reading 0.
- R2: A synchronous reset clears every selection field and the alternate clock bit. After reset, all pins therefore carry port data, and every peripheral input selects pin 0.
- R3: A peripheral input whose field holds a value v below the pin count follows `pin_in[v]`.
- R4: A peripheral input whose field holds a value at or above the pin count reads 0.
- R5: A peripheral input that selects a pin whose `pin_analog` bit is set reads 0, whatever the pin level.
- R6: A pin whose code c lies in 1 to 5 is driven with `periph_out[c-1]`, and its `pad_oe` is 1. Code 3 is the serial clock.
- R7: A pin with code 0, or with any code above 5, is driven as null: `pad_out` follows `port_out` and `pad_oe` follows `port_oe`.
- R8: A pin with `ded_en` set drives `ded_out` with `pad_oe` at 1, overriding both remapped and port outputs.
- R9: Peripheral input fields never affect `pad_out` or `pad_oe`.
- R10: While the alternate clock bit is set:
  - `alt_sclk_pad` equals `periph_out[2]`.
  - Every pin whose code is 3 behaves as null.

  While the bit is clear, `alt_sclk_pad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| pin_in | input | 8 | Pin levels seen from the pads |
| pin_analog | input | 8 | Per-pin analog mode flag |
| port_out | input | 8 | General port output data |
| port_oe | input | 8 | General port output enable |
| ded_en | input | 8 | Dedicated function owns the pin |
| ded_out | input | 8 | Dedicated function output data |
| periph_out | input | 5 | Remappable peripheral outputs, code c drives index c-1 |
| periph_in | output | 6 | Remapped peripheral inputs |
| pad_out | output | 8 | Resolved pad output data |
| pad_oe | output | 8 | Resolved pad output enable |
| alt_sclk_pad | output | 1 | Fixed alternate serial clock pad |

## Verification
A register write is due at the rising edge that samples `cfg_we`. The bench therefore raises the strobe after a falling edge, drops it at the next falling edge, and only then reads back or checks routing. Every routing result is combinational and due in the same cycle as its stimulus. The bench changes pins, port data or peripheral outputs and samples one time unit later, well away from any rising edge. Read-back is also combinational: the bench sets the address and samples after the same short settling delay.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int SEL_W  = 6;
  localparam int REG_W  = 16;
  localparam int HI_LSB = 8;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/pxb_cfg_regs.sv
module pxb_cfg_regs
  import pxb_pkg::*;
#(
  parameter int NUM_PIN_IN = 6,
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 3,
  parameter int OUT_BASE   = 3,
  parameter int ALT_ADDR   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output sel_t              in_sel  [NUM_PIN_IN],
  output sel_t              out_sel [NUM_PINS],
  output logic              alt_en
);

  for (genvar f = 0; f < NUM_PIN_IN; f++) begin : g_in
    localparam int LSB = (f % 2) * HI_LSB;
    always_ff @(posedge clk) begin
      if (rst) in_sel[f] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(f / 2)) in_sel[f] <= cfg_wdata[LSB +: SEL_W];
    end
    // R1
    r1_in_write_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_we && cfg_addr == ADDR_W'(f / 2) |=> in_sel[f] == $past(cfg_wdata[LSB +: SEL_W]));
    // R2
    r2_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> in_sel[f] == '0);
  end

  for (genvar f = 0; f < NUM_PINS; f++) begin : g_out
    localparam int LSB = (f % 2) * HI_LSB;
    always_ff @(posedge clk) begin
      if (rst) out_sel[f] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(OUT_BASE + f / 2)) out_sel[f] <= cfg_wdata[LSB +: SEL_W];
    end
    // R2
    r2_out_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> out_sel[f] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) alt_en <= 1'b0;
    else if (cfg_we && cfg_addr == ADDR_W'(ALT_ADDR)) alt_en <= cfg_wdata[0];
  end

  always_comb begin
    cfg_rdata = '0;
    for (int f = 0; f < NUM_PIN_IN; f++)
      if (cfg_addr == ADDR_W'(f / 2)) cfg_rdata[(f % 2) * HI_LSB +: SEL_W] = in_sel[f];
    for (int f = 0; f < NUM_PINS; f++)
      if (cfg_addr == ADDR_W'(OUT_BASE + f / 2)) cfg_rdata[(f % 2) * HI_LSB +: SEL_W] = out_sel[f];
    if (cfg_addr == ADDR_W'(ALT_ADDR)) cfg_rdata[0] = alt_en;
  end

endmodule

// File: rtl/pxb_in_route.sv
module pxb_in_route
  import pxb_pkg::*;
#(
  parameter int NUM_PIN_IN = 6,
  parameter int NUM_PINS   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  sel_t                  in_sel [NUM_PIN_IN],
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [NUM_PINS-1:0]   pin_analog,
  output logic [NUM_PIN_IN-1:0] periph_in
);

  logic [NUM_PINS-1:0] pin_digital;
  assign pin_digital = pin_in & ~pin_analog;

  for (genvar i = 0; i < NUM_PIN_IN; i++) begin : g_sel
    always_comb begin
      periph_in[i] = 1'b0;
      for (int p = 0; p < NUM_PINS; p++)
        if (in_sel[i] == SEL_W'(p)) periph_in[i] = pin_digital[p];
    end
    // R4
    r4_range_chk: assert property (@(posedge clk) disable iff (rst)
      in_sel[i] >= SEL_W'(NUM_PINS) |-> !periph_in[i]);
    // R5
    r5_analog_chk: assert property (@(posedge clk) disable iff (rst)
      (in_sel[i] < SEL_W'(NUM_PINS)) && |(pin_analog & (NUM_PINS'(1) << in_sel[i])) |-> !periph_in[i]);
  end

endmodule

// File: rtl/pxb_out_route.sv
module pxb_out_route
  import pxb_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int NUM_POUT  = 5,
  parameter int SCLK_CODE = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  sel_t                out_sel [NUM_PINS],
  input  logic                alt_en,
  input  logic [NUM_POUT-1:0] periph_out,
  input  logic [NUM_PINS-1:0] port_out,
  input  logic [NUM_PINS-1:0] port_oe,
  input  logic [NUM_PINS-1:0] ded_en,
  input  logic [NUM_PINS-1:0] ded_out,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic remap_hit;
    logic remap_val;

    always_comb begin
      remap_hit = 1'b0;
      remap_val = 1'b0;
      for (int c = 1; c <= NUM_POUT; c++) begin
        if (out_sel[p] == SEL_W'(c) && !(alt_en && c == SCLK_CODE)) begin
          remap_hit = 1'b1;
          remap_val = periph_out[c-1];
        end
      end
    end

    always_comb begin
      if (ded_en[p]) begin
        pad_out[p] = ded_out[p];
        pad_oe[p]  = 1'b1;
      end else if (remap_hit) begin
        pad_out[p] = remap_val;
        pad_oe[p]  = 1'b1;
      end else begin
        pad_out[p] = port_out[p];
        pad_oe[p]  = port_oe[p];
      end
    end

    // R8
    r8_ded_prio_chk: assert property (@(posedge clk) disable iff (rst)
      ded_en[p] |-> pad_oe[p] && pad_out[p] == ded_out[p]);
    // R7
    r7_null_chk: assert property (@(posedge clk) disable iff (rst)
      !ded_en[p] && (out_sel[p] == '0 || out_sel[p] > SEL_W'(NUM_POUT))
        |-> pad_out[p] == port_out[p] && pad_oe[p] == port_oe[p]);
    // R10
    r10_alt_block_chk: assert property (@(posedge clk) disable iff (rst)
      !ded_en[p] && alt_en && out_sel[p] == SEL_W'(SCLK_CODE)
        |-> pad_out[p] == port_out[p] && pad_oe[p] == port_oe[p]);
  end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pxb_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int NUM_PIN_IN = 6,
  parameter int NUM_POUT   = 5,
  parameter int SCLK_CODE  = 3,
  localparam int IN_REGS   = (NUM_PIN_IN + 1) / 2,
  localparam int OUT_REGS  = (NUM_PINS + 1) / 2,
  localparam int OUT_BASE  = IN_REGS,
  localparam int ALT_ADDR  = IN_REGS + OUT_REGS,
  localparam int ADDR_W    = $clog2(ALT_ADDR + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [15:0]           cfg_wdata,
  output logic [15:0]           cfg_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [NUM_PINS-1:0]   pin_analog,
  input  logic [NUM_PINS-1:0]   port_out,
  input  logic [NUM_PINS-1:0]   port_oe,
  input  logic [NUM_PINS-1:0]   ded_en,
  input  logic [NUM_PINS-1:0]   ded_out,
  input  logic [NUM_POUT-1:0]   periph_out,
  output logic [NUM_PIN_IN-1:0] periph_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic                  alt_sclk_pad
);

  sel_t in_sel  [NUM_PIN_IN];
  sel_t out_sel [NUM_PINS];
  logic alt_en;

  pxb_cfg_regs #(
    .NUM_PIN_IN(NUM_PIN_IN), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
    .OUT_BASE(OUT_BASE), .ALT_ADDR(ALT_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_sel(in_sel), .out_sel(out_sel), .alt_en(alt_en)
  );

  pxb_in_route #(.NUM_PIN_IN(NUM_PIN_IN), .NUM_PINS(NUM_PINS)) u_in (
    .clk(clk), .rst(rst), .in_sel(in_sel), .pin_in(pin_in),
    .pin_analog(pin_analog), .periph_in(periph_in)
  );

  pxb_out_route #(.NUM_PINS(NUM_PINS), .NUM_POUT(NUM_POUT), .SCLK_CODE(SCLK_CODE)) u_out (
    .clk(clk), .rst(rst), .out_sel(out_sel), .alt_en(alt_en),
    .periph_out(periph_out), .port_out(port_out), .port_oe(port_oe),
    .ded_en(ded_en), .ded_out(ded_out), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign alt_sclk_pad = alt_en & periph_out[SCLK_CODE-1];

  // R10
  r10_alt_pad_chk: assert property (@(posedge clk) disable iff (rst)
    !alt_en |-> !alt_sclk_pad);

endmodule

// File: tb/pin_xbar_test.sv
module pin_xbar_test;
  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [2:0] cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic [7:0] pin_in, pin_analog, port_out, port_oe, ded_en, ded_out;
  logic [4:0] periph_out;
  logic [5:0] periph_in;
  logic [7:0] pad_out, pad_oe;
  logic alt_sclk_pad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_xbar uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
    .pin_analog(pin_analog), .port_out(port_out), .port_oe(port_oe),
    .ded_en(ded_en), .ded_out(ded_out), .periph_out(periph_out),
    .periph_in(periph_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_sclk_pad(alt_sclk_pad)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_chk("R2 regs zero", 3'(a), 16'h0000);
    pin_in = 8'h01; pin_analog = 8'h00; port_out = 8'hA5; port_oe = 8'h3C;
    #1;
    chk("R2 inputs select pin0", {10'd0, periph_in}, 16'h003F);
    chk("R2 pad_out is port", {8'd0, pad_out}, 16'h00A5);
    chk("R2 pad_oe is port", {8'd0, pad_oe}, 16'h003C);
    chk("R10 alt pad idle", {15'd0, alt_sclk_pad}, 16'h0000);
  endtask

  task automatic t_readback;
    wr(3'd0, 16'hFFFF);
    rd_chk("R1 unused bits zero", 3'd0, 16'h3F3F);
    wr(3'd4, 16'h1234);
    rd_chk("R1 field layout", 3'd4, 16'h1234);
    wr(3'd7, 16'hFFFF);
    rd_chk("R1 alt bit only", 3'd7, 16'h0001);
    wr(3'd7, 16'h0000);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_in_route;
    wr(3'd0, 16'h0502);
    wr(3'd1, 16'h0700);
    wr(3'd2, 16'h0803);
    pin_analog = 8'h00;
    pin_in = 8'b1010_0100; #1;
    chk("R3 route pattern A", {10'd0, periph_in}, 16'h000B);
    pin_in = 8'b0101_1011; #1;
    chk("R3 route pattern B", {10'd0, periph_in}, 16'h0014);
    pin_in = 8'hFF; #1;
    chk("R4 out of range reads 0", {10'd0, periph_in}, 16'h001F);
  endtask

  task automatic t_analog;
    pin_in = 8'hFF; pin_analog = 8'b0000_0100; #1;
    chk("R5 analog pin gated", {10'd0, periph_in}, 16'h001E);
    pin_analog = 8'b1000_1000; #1;
    chk("R5 analog pins 3 7 gated", {10'd0, periph_in}, 16'h0007);
    pin_analog = 8'h00;
  endtask

  task automatic t_out_route;
    wr(3'd3, 16'h0201);
    wr(3'd4, 16'h0504);
    wr(3'd5, 16'h0006);
    wr(3'd6, 16'h3F03);
    port_out = 8'b1011_0000; port_oe = 8'b0010_0000; ded_en = 8'h00;
    periph_out = 5'b10101; #1;
    chk("R6 pad_out pattern A", {8'd0, pad_out}, 16'h00F9);
    chk("R6 R7 pad_oe", {8'd0, pad_oe}, 16'h006F);
    periph_out = 5'b01010; #1;
    chk("R6 R7 pad_out pattern B", {8'd0, pad_out}, 16'h00B6);
  endtask

  task automatic t_priority;
    ded_en = 8'b0001_0011; ded_out = 8'b0000_0001; #1;
    chk("R8 dedicated wins data", {8'd0, pad_out}, 16'h00A5);
    chk("R8 dedicated wins oe", {8'd0, pad_oe}, 16'h007F);
    ded_en = 8'h00; ded_out = 8'h00;
  endtask

  task automatic t_no_own;
    for (int a = 3; a < 7; a++) wr(3'(a), 16'h0000);
    port_out = 8'hC3; port_oe = 8'h5A; #1;
    chk("R9 oe by port", {8'd0, pad_oe}, 16'h005A);
    wr(3'd0, 16'h0701);
    wr(3'd1, 16'h0304);
    chk("R9 oe unchanged after input writes", {8'd0, pad_oe}, 16'h005A);
    chk("R9 data unchanged after input writes", {8'd0, pad_out}, 16'h00C3);
  endtask

  task automatic t_alt;
    wr(3'd3, 16'h0003);
    wr(3'd6, 16'h0003);
    port_out = 8'h00; port_oe = 8'h00; periph_out = 5'b00100; #1;
    chk("R6 clock via table", {8'd0, pad_out}, 16'h0041);
    chk("R10 alt pad off while clear", {15'd0, alt_sclk_pad}, 16'h0000);
    wr(3'd7, 16'h0001);
    chk("R10 table clock blanked data", {8'd0, pad_out}, 16'h0000);
    chk("R10 table clock blanked oe", {8'd0, pad_oe}, 16'h0000);
    chk("R10 alt pad carries clock", {15'd0, alt_sclk_pad}, 16'h0001);
    periph_out = 5'b11011; #1;
    chk("R10 alt pad follows clock low", {15'd0, alt_sclk_pad}, 16'h0000);
    wr(3'd7, 16'h0000);
    periph_out = 5'b00100; #1;
    chk("R10 table restored", {8'd0, pad_out}, 16'h0041);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pin_in = '0; pin_analog = '0; port_out = '0; port_oe = '0;
    ded_en = '0; ded_out = '0; periph_out = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_in_route();
    t_analog();
    t_out_route();
    t_priority();
    t_no_own();
    t_alt();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule